// File: doc/BRIEF.md
# Sigma-Delta Result Correction Pipeline

This block turns raw signed words from a sigma-delta decimation filter into finished 16-bit conversion codes. Each incoming word carries a 2-bit channel index. The block can first average pairs of filter outputs when chopping is enabled. It then removes a per-channel offset and applies a per-channel gain. Last, it rounds the value to 16 bits in either two's complement or unipolar coding, and saturates it at full scale instead of letting it wrap.

The correction coefficients live in small per-channel register banks. The banks load preset values at reset, and a simple write port can overwrite them afterwards, for example with values found by a calibration routine. A result leaves the block with a valid strobe and the channel index it arrived with. The pipeline has a fixed depth of three registers, so the delay from input to output is always the same.

Top module: `adc_result_corr`

## Requirements
- R1: While reset is applied, and after its synchronised release, `out_valid` is low. After reset every channel's offset is `OFS_DEF` (0) and its gain is `GAIN_DEF` (0x8000).
- R2: An input word is accepted on a rising edge where `in_valid` is high. Without chopping, every accepted word gives exactly one result. That result has `out_valid` high directly after the third rising edge, counting the accepting edge as the first. At no other time is `out_valid` high.
- R3: With `chop_en` high, accepted words form pairs. The first word of a pair gives no result. The second word gives one result, formed from the average floor((a+b+1)/2). An edge that samples `chop_en` low throws away a pending first word.
- R4: The offset is a 16-bit two's complement value. It is multiplied by 256 and subtracted from the 24-bit signed sample or average, before the gain is applied.
- R5: The gain is an unsigned 16-bit value, where 0x8000 means 1.0. The corrected value is q = floor((d*gain + 2^14) / 2^15), where d is the offset-corrected value.
- R6: With `fmt_unipolar` low, the code is floor((q+128)/256), clamped to the range -32768..32767 and output in two's complement.
- R7: With `fmt_unipolar` high, the code is floor((q+64)/128), clamped to the range 0..65535 and output as an unsigned value.
- R8: A rising edge with `cfg_we` high writes `cfg_wdata` into one register. If `cfg_gain_sel` is 1, the target is the gain of channel `cfg_chan`; if it is 0, the target is the offset of that channel. No other channel and no other coefficient changes.
- R9: `out_chan` equals the `in_chan` of the word that produced the result. In chop mode, that is the second word of the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Filter word qualifier |
| in_data | input | 24 | Signed filter word |
| in_chan | input | 2 | Channel index travelling with the word |
| chop_en | input | 1 | 1 = average pairs of words |
| fmt_unipolar | input | 1 | 1 = unipolar coding, 0 = two's complement coding |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_gain_sel | input | 1 | 1 = write gain, 0 = write offset |
| cfg_chan | input | 2 | Channel whose coefficient is written |
| cfg_wdata | input | 16 | Coefficient value |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 16 | Corrected 16-bit code |
| out_chan | output | 2 | Channel of the result |

## Verification
The assertions check the following on every cycle:
- the fixed three-edge relation between `out_valid` and an earlier accepted word;
- that an unpaired first chop word stays silent;
- that the channel index is carried through outside chop mode;
- that coefficients hold when no write is made;
- the saturation to 0x7FFF in two's complement and to zero in unipolar coding.

The arithmetic values need the bench's scenarios, which a behavioural reference model checks. These values are the rounding at both rounding points, the signed offset alignment, fractional gains and the pair average. The same applies to pair loss when chopping is switched off, and to the isolation of coefficient writes between channels and banks.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  // Output coding selected by the format input
  typedef enum logic {
    FMT_TWOS     = 1'b0,
    FMT_UNIPOLAR = 1'b1
  } out_fmt_e;

  // Coefficient bank addressed by a write
  typedef enum logic {
    BANK_OFFSET = 1'b0,
    BANK_GAIN   = 1'b1
  } coef_bank_e;
endpackage

// File: rtl/acr_chop_avg.sv
// Stage 1: optional pairwise averaging (R3) or straight pass (R2).
module acr_chop_avg #(
  parameter int SAMP_W = 24,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_data,
  input  logic [CH_W-1:0]   in_chan,
  input  logic              chop_en,
  output logic              o_valid,
  output logic [SAMP_W-1:0] o_data,
  output logic [CH_W-1:0]   o_chan
);
  localparam int SUM_W = SAMP_W + 1;

  logic              pend_q, pend_d;
  logic [SAMP_W-1:0] hold_q;
  logic              hold_en;
  logic              v_d;
  logic [SAMP_W-1:0] data_d;
  logic signed [SUM_W-1:0] pair_sum;

  // round-half-up average: (a + b + 1) >> 1, arithmetic
  assign pair_sum = $signed({hold_q[SAMP_W-1], hold_q})
                  + $signed({in_data[SAMP_W-1], in_data})
                  + SUM_W'(1);

  always_comb begin
    pend_d  = pend_q;
    hold_en = 1'b0;
    v_d     = 1'b0;
    data_d  = in_data;
    if (!chop_en) begin
      pend_d = 1'b0;
      v_d    = in_valid;
    end else if (in_valid) begin
      if (!pend_q) begin
        pend_d  = 1'b1;
        hold_en = 1'b1;
      end else begin
        pend_d = 1'b0;
        v_d    = 1'b1;
        data_d = SAMP_W'(pair_sum >>> 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      o_valid <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      o_valid <= v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      o_data <= '0;
      o_chan <= '0;
    end else begin
      if (hold_en) hold_q <= in_data;
      if (v_d) begin
        o_data <= data_d;
        o_chan <= in_chan;
      end
    end
  end

  // first word of a pair never yields a result
  assert_first_half_silent_R3: assert property (
    @(posedge clk) disable iff (!rst_ni)
    (in_valid && chop_en && !pend_q) |=> !o_valid);
endmodule

// File: rtl/acr_coef_bank.sv
// Per-channel offset and gain registers with preset reset values (R1, R8).
module acr_coef_bank
  import adc_corr_pkg::*;
#(
  parameter int                NCH      = 4,
  parameter int                COEF_W   = 16,
  parameter logic [COEF_W-1:0] OFS_DEF  = '0,
  parameter logic [COEF_W-1:0] GAIN_DEF = 16'h8000,
  localparam int               CH_W     = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  coef_bank_e        wr_bank,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [COEF_W-1:0] wr_data,
  input  logic [CH_W-1:0]   ofs_chan,
  output logic [COEF_W-1:0] ofs_val,
  input  logic [CH_W-1:0]   gain_chan,
  output logic [COEF_W-1:0] gain_val
);
  logic [COEF_W-1:0] ofs_q  [NCH];
  logic [COEF_W-1:0] gain_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic ofs_en, gain_en;

    always_comb begin
      ofs_en  = wr_en && (wr_chan == CH_W'(c)) && (wr_bank == BANK_OFFSET);
      gain_en = wr_en && (wr_chan == CH_W'(c)) && (wr_bank == BANK_GAIN);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        ofs_q[c]  <= OFS_DEF;
        gain_q[c] <= GAIN_DEF;
      end else begin
        if (ofs_en)  ofs_q[c]  <= wr_data;
        if (gain_en) gain_q[c] <= wr_data;
      end
    end

    // coefficients move only on a write strobe
    assert_coef_hold_R8: assert property (
      @(posedge clk) disable iff (!rst_ni)
      !wr_en |=> ($stable(ofs_q[c]) && $stable(gain_q[c])));
  end

  assign ofs_val  = ofs_q[ofs_chan];
  assign gain_val = gain_q[gain_chan];
endmodule

// File: rtl/acr_offset_sub.sv
// Stage 2: subtract the offset, aligned to the upper bits of the sample (R4).
module acr_offset_sub #(
  parameter int SAMP_W = 24,
  parameter int COEF_W = 16,
  parameter int CH_W   = 2,
  localparam int DIFF_W = SAMP_W + 1,
  localparam int OSH    = SAMP_W - COEF_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              i_valid,
  input  logic [SAMP_W-1:0] i_data,
  input  logic [CH_W-1:0]   i_chan,
  input  logic [COEF_W-1:0] ofs,
  output logic              o_valid,
  output logic [DIFF_W-1:0] o_diff,
  output logic [CH_W-1:0]   o_chan
);
  logic signed [DIFF_W-1:0] samp_x, ofs_x, diff_d;

  always_comb begin
    samp_x = $signed({i_data[SAMP_W-1], i_data});
    ofs_x  = $signed({{(DIFF_W-COEF_W-OSH){ofs[COEF_W-1]}}, ofs, {OSH{1'b0}}});
    diff_d = samp_x - ofs_x;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) o_valid <= 1'b0;
    else         o_valid <= i_valid;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      o_diff <= '0;
      o_chan <= '0;
    end else if (i_valid) begin
      o_diff <= diff_d;
      o_chan <= i_chan;
    end
  end
endmodule

// File: rtl/acr_gain_fmt.sv
// Stage 3: gain scaling (R5), rounding, coding and clamping (R6, R7).
module acr_gain_fmt
  import adc_corr_pkg::*;
#(
  parameter int SAMP_W = 24,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16,
  parameter int CH_W   = 2,
  localparam int DIFF_W = SAMP_W + 1,
  localparam int PW     = DIFF_W + COEF_W + 1,
  localparam int GFR    = COEF_W - 1,
  localparam int TSH    = SAMP_W - OUT_W,
  localparam int USH    = TSH - 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              i_valid,
  input  logic [DIFF_W-1:0] i_diff,
  input  logic [CH_W-1:0]   i_chan,
  input  logic [COEF_W-1:0] gain,
  input  out_fmt_e          fmt,
  output logic              o_valid,
  output logic [OUT_W-1:0]  o_data,
  output logic [CH_W-1:0]   o_chan
);
  localparam logic signed [PW-1:0] GRND = PW'(1) <<< (GFR - 1);
  localparam logic signed [PW-1:0] TRND = PW'(1) <<< (TSH - 1);
  localparam logic signed [PW-1:0] URND = PW'(1) <<< (USH - 1);
  localparam logic signed [PW-1:0] TMAX = (PW'(1) <<< (OUT_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] TMIN = -(PW'(1) <<< (OUT_W - 1));
  localparam logic signed [PW-1:0] UMAX = (PW'(1) <<< OUT_W) - PW'(1);

  logic signed [PW-1:0] prod, q, t, u;
  logic                 t_hi, t_lo, u_hi, u_lo;
  logic [OUT_W-1:0]     t_code, u_code, code_d;

  always_comb begin
    prod = PW'($signed(i_diff)) * PW'($signed({1'b0, gain}));
    q    = (prod + GRND) >>> GFR;
    t    = (q + TRND) >>> TSH;
    u    = (q + URND) >>> USH;
    t_hi = t > TMAX;
    t_lo = t < TMIN;
    u_hi = u > UMAX;
    u_lo = u[PW-1];
    t_code = t_hi ? OUT_W'(TMAX) : (t_lo ? OUT_W'(TMIN) : OUT_W'(t));
    u_code = u_hi ? OUT_W'(UMAX) : (u_lo ? '0 : OUT_W'(u));
    code_d = (fmt == FMT_UNIPOLAR) ? u_code : t_code;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) o_valid <= 1'b0;
    else         o_valid <= i_valid;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      o_data <= '0;
      o_chan <= '0;
    end else if (i_valid) begin
      o_data <= code_d;
      o_chan <= i_chan;
    end
  end

  assert_twos_clamp_hi_R6: assert property (
    @(posedge clk) disable iff (!rst_ni)
    (i_valid && fmt == FMT_TWOS && t_hi) |=> (o_data == {1'b0, {(OUT_W-1){1'b1}}}));

  assert_uni_clamp_lo_R7: assert property (
    @(posedge clk) disable iff (!rst_ni)
    (i_valid && fmt == FMT_UNIPOLAR && u_lo) |=> (o_data == '0));
endmodule

// File: rtl/adc_result_corr.sv
module adc_result_corr
  import adc_corr_pkg::*;
#(
  parameter int                SAMP_W   = 24,
  parameter int                COEF_W   = 16,
  parameter int                OUT_W    = 16,
  parameter int                NCH      = 4,
  parameter logic [COEF_W-1:0] OFS_DEF  = '0,
  parameter logic [COEF_W-1:0] GAIN_DEF = 16'h8000,
  localparam int               CH_W     = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_data,
  input  logic [CH_W-1:0]   in_chan,
  input  logic              chop_en,
  input  logic              fmt_unipolar,
  input  logic              cfg_we,
  input  logic              cfg_gain_sel,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [COEF_W-1:0] cfg_wdata,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic [CH_W-1:0]   out_chan
);
  localparam int DIFF_W = SAMP_W + 1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic              s1_valid, s2_valid;
  logic [SAMP_W-1:0] s1_data;
  logic [CH_W-1:0]   s1_chan, s2_chan;
  logic [DIFF_W-1:0] s2_diff;
  logic [COEF_W-1:0] ofs_val, gain_val;

  acr_chop_avg #(.SAMP_W(SAMP_W), .CH_W(CH_W)) u_avg (
    .clk(clk), .rst_ni(rst_s),
    .in_valid(in_valid), .in_data(in_data), .in_chan(in_chan), .chop_en(chop_en),
    .o_valid(s1_valid), .o_data(s1_data), .o_chan(s1_chan)
  );

  acr_coef_bank #(.NCH(NCH), .COEF_W(COEF_W), .OFS_DEF(OFS_DEF), .GAIN_DEF(GAIN_DEF)) u_coef (
    .clk(clk), .rst_ni(rst_s),
    .wr_en(cfg_we), .wr_bank(coef_bank_e'(cfg_gain_sel)), .wr_chan(cfg_chan), .wr_data(cfg_wdata),
    .ofs_chan(s1_chan), .ofs_val(ofs_val),
    .gain_chan(s2_chan), .gain_val(gain_val)
  );

  acr_offset_sub #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .CH_W(CH_W)) u_ofs (
    .clk(clk), .rst_ni(rst_s),
    .i_valid(s1_valid), .i_data(s1_data), .i_chan(s1_chan), .ofs(ofs_val),
    .o_valid(s2_valid), .o_diff(s2_diff), .o_chan(s2_chan)
  );

  acr_gain_fmt #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .CH_W(CH_W)) u_gain (
    .clk(clk), .rst_ni(rst_s),
    .i_valid(s2_valid), .i_diff(s2_diff), .i_chan(s2_chan), .gain(gain_val),
    .fmt(out_fmt_e'(fmt_unipolar)),
    .o_valid(out_valid), .o_data(out_data), .o_chan(out_chan)
  );

  // no result while reset holds the pipeline
  assert_quiet_in_reset_R1: assert property (
    @(posedge clk) !rst_s |-> !out_valid);

  // every result traces back to a word accepted three edges earlier
  assert_fixed_latency_R2: assert property (
    @(posedge clk) disable iff (!rst_s)
    out_valid |-> $past(in_valid, 3));

  // outside chop mode the channel index comes out unchanged
  assert_chan_follow_R9: assert property (
    @(posedge clk) disable iff (!rst_s)
    (out_valid && !$past(chop_en, 3)) |-> (out_chan == $past(in_chan, 3)));
endmodule

// File: tb/adc_result_corr_tb.sv
`timescale 1ns/1ps
module adc_result_corr_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_data;
  logic [1:0]  in_chan;
  logic        chop_en, fmt_unipolar;
  logic        cfg_we, cfg_gain_sel;
  logic [1:0]  cfg_chan;
  logic [15:0] cfg_wdata;
  logic        out_valid;
  logic [15:0] out_data;
  logic [1:0]  out_chan;

  always #10 clk = ~clk;  // 50 MHz

  adc_result_corr u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_chan(in_chan),
    .chop_en(chop_en), .fmt_unipolar(fmt_unipolar), .cfg_we(cfg_we), .cfg_gain_sel(cfg_gain_sel),
    .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  bit    done     = 0;
  bit    chk_on   = 0;
  bit    model_on = 0;
  string cur_req  = "R1";

  // behavioural reference state
  logic [15:0] m_ofs  [4];
  logic [15:0] m_gain [4];
  bit          m_pend;
  longint      m_hold;
  bit          pv [4];
  logic [15:0] pd [4];
  logic [1:0]  pc [4];

  function automatic logic [15:0] ref_code(longint x, int ch, bit uni);
    longint d, p, q, r;
    d = x - longint'($signed(m_ofs[ch])) * 256;          // R4
    p = d * longint'(m_gain[ch]);                         // R5
    q = (p + 16384) >>> 15;
    if (uni) begin                                        // R7
      r = (q + 64) >>> 7;
      if (r > 65535) r = 65535;
      if (r < 0) r = 0;
    end else begin                                        // R6
      r = (q + 128) >>> 8;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
    end
    return r[15:0];
  endfunction

  always @(posedge clk) begin
    bit          nv;
    logic [15:0] nd;
    logic [1:0]  nc;
    longint      x;
    nv = 0; nd = '0; nc = '0;
    if (!model_on) begin
      for (int c = 0; c < 4; c++) begin m_ofs[c] = 16'h0000; m_gain[c] = 16'h8000; end  // R1
      m_pend = 0;
      for (int i = 0; i < 4; i++) pv[i] = 0;
    end else begin
      if (cfg_we) begin                                   // R8
        if (cfg_gain_sel) m_gain[cfg_chan] = cfg_wdata;
        else              m_ofs[cfg_chan]  = cfg_wdata;
      end
      x = longint'($signed(in_data));
      if (!chop_en) begin
        m_pend = 0;
        if (in_valid) begin nv = 1; nd = ref_code(x, in_chan, fmt_unipolar); nc = in_chan; end
      end else if (in_valid) begin                        // R3
        if (!m_pend) begin m_pend = 1; m_hold = x; end
        else begin
          m_pend = 0; nv = 1; nc = in_chan;
          nd = ref_code((m_hold + x + 1) >>> 1, in_chan, fmt_unipolar);
        end
      end
      pv[3] = pv[2]; pd[3] = pd[2]; pc[3] = pc[2];
      pv[2] = pv[1]; pd[2] = pd[1]; pc[2] = pc[1];
      pv[1] = nv;    pd[1] = nd;    pc[1] = nc;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_checks++;
      if (out_valid !== pv[3]) begin
        n_fail++;
        $display("FAIL %s out_valid actual=%0b expected=%0b at cycle %0d", cur_req, out_valid, pv[3], cyc);
      end else if (pv[3] && (out_data !== pd[3] || out_chan !== pc[3])) begin
        n_fail++;
        $display("FAIL %s data/chan actual=%h/%0d expected=%h/%0d at cycle %0d",
                 cur_req, out_data, out_chan, pd[3], pc[3], cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int d, logic [1:0] ch);
    in_valid = 1; in_data = d[23:0]; in_chan = ch;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wr(bit is_gain, logic [1:0] ch, logic [15:0] v);
    cfg_we = 1; cfg_gain_sel = is_gain; cfg_chan = ch; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_data = '0; in_chan = '0; chop_en = 0; fmt_unipolar = 0;
    cfg_we = 0; cfg_gain_sel = 0; cfg_chan = '0; cfg_wdata = '0;
    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 out_valid in reset actual=%0b expected=0", out_valid);
      end
    end
    rst_n = 1;
    idle(3);
    model_on = 1; chk_on = 1;
    idle(2);

    // R1/R2: default coefficients, single words and rounding at 128
    cur_req = "R1";
    send(0, 0); idle(4);
    send(256, 1); idle(4);
    send(383, 2); send(384, 3); send(-385, 0); idle(5);

    // R2: back-to-back and gapped words, R9 channels mixed
    cur_req = "R2";
    send(32'h12345, 3); send(-32'h40000, 1); idle(1); send(32'h7FFF00, 2); idle(2);
    send(-5000, 0); send(127, 1); send(-128, 2); idle(5);
    cur_req = "R9";
    for (int i = 0; i < 8; i++) send(i * 40000 - 150000, 2'(i));
    idle(5);

    // R4/R8: per-channel offsets, negative one included
    cur_req = "R8";
    wr(0, 0, 16'h0010); wr(0, 1, 16'hFF80); wr(0, 3, 16'h1234); idle(4);
    for (int i = 0; i < 8; i++) send(i * 12345 - 40000, 2'(i));
    idle(5);
    cur_req = "R4";
    send(32'h001000, 0); send(-32'h8000, 1); send(32'h120000, 3); send(777, 2); idle(5);

    // R5: fractional gains, rounding at bit 14
    cur_req = "R5";
    wr(1, 0, 16'h4000); wr(1, 1, 16'h6001); wr(1, 2, 16'h0001); wr(1, 3, 16'hFFFF); idle(4);
    send(32'h1FF, 0); send(32'h201, 0); send(-32'h12345, 1); send(32'h7FFFFF, 2);
    send(32'h3333, 3); send(-513, 0); idle(5);

    // R6: two's complement clamping both ways
    cur_req = "R6";
    wr(0, 3, 16'h0000); idle(4);
    send(32'h600000, 3); send(-32'h600000, 3); send(32'h3FFF7F, 3); send(-32'h400000, 3); idle(5);

    // R7: unipolar coding
    cur_req = "R7";
    fmt_unipolar = 1; idle(4);
    send(-1000, 3); send(32'h200000, 3); send(32'h600000, 0); send(63, 2); send(32'h7FFFFF, 1);
    send(-32'h800000, 0); idle(5);
    fmt_unipolar = 0; idle(4);

    // R3: chop averaging, pairs, odd sums, pair loss
    cur_req = "R3";
    wr(1, 0, 16'h8000); wr(0, 0, 16'h0000); wr(1, 2, 16'h8000); wr(0, 2, 16'h0000); idle(4);
    chop_en = 1; idle(1);
    send(25600, 0); send(25857, 2); idle(4);
    send(-768, 2); idle(2); send(-1023, 0); idle(4);
    send(32'h7FFFFF, 0); send(32'h7FFFFF, 0); send(100, 2); send(-101, 2); idle(5);
    send(50000, 0); idle(1);
    chop_en = 0; idle(2);       // pending word discarded
    chop_en = 1; idle(1);
    send(1280, 2); send(1536, 0); idle(5);
    chop_en = 0; idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule